// File: doc/BRIEF.md
# DMA Channel Service Sequencer

This block serves the channels of one DMA controller, four by default. It scans the channels that are unmasked and are requesting. It grants the lowest-numbered one. It then holds that grant until the requesting device reports that one transfer beat is done. After the beat it advances that channel's current count, reports the new value in words and in bytes, and decides whether the channel has reached terminal count.

Each channel carries a mode byte with four fields:

| Bits | Field | Values |
|------|-------|--------|
| 7:6 | Service style | 0 demand, 1 single, 2 block, 3 cascade |
| 5 | Address direction | 1 = address goes down |
| 4 | Auto-initialise | 1 = enabled |
| 3:2 | Transfer type | 0 verify, 1 write, 2 read, 3 illegal |

Terminal count is reached when the incremented count equals the channel's base count plus one. A channel in cascade style never raises terminal count. At terminal count, one of two things happens:
- If auto-initialise is set, the channel rewinds its count to zero.
- If auto-initialise is clear, the channel masks itself.

The sequencer has three states:
- SV_IDLE: the scan. It moves to SV_GRANT when any channel is eligible.
- SV_GRANT: the grant is held. It returns to SV_IDLE when the controller is disabled, which is an abort. It moves to SV_UPDATE when a beat-done strobe arrives.
- SV_UPDATE: one cycle that publishes the count update and any terminal-count pulse. It always returns to SV_IDLE.

Top module: `dma_svc_engine`

## Requirements
- R1: While `ctl_disable` is 1, no grant is given. Raising it during a grant withdraws the grant on the next cycle and produces no count update.
- R2: A channel is eligible only when its `mask_q` bit is 0 and its `req` bit is 1.
- R3: Among eligible channels, the lowest index is granted.
- R4: `grant` is one-hot or zero. Once given, it stays unchanged until `beat_done` or `ctl_disable` arrives. It is zero in the cycle that follows `beat_done`.
- R5: In the cycle after `beat_done` is sampled during a grant, `upd_valid` is 1 for exactly one cycle. In that cycle `upd_ch` is the granted channel and `upd_count` is that channel's previous count plus one. Counts are zero after reset.
- R6: `upd_bytes` is `upd_count` shifted left by one when WIDE=1, and equals `upd_count` when WIDE=0.
- R7: In the update cycle, `tc_pulse[n]` is 1 when the new count equals base count + 1 and mode bits 7:6 are 0, 1 or 2.
- R8: A channel whose mode bits 7:6 equal 3 (cascade) never pulses terminal count and never changes its own mask bit.
- R9: At terminal count with mode bit 4 set (auto-initialise), the channel's count returns to 0.
- R10: At terminal count with mode bit 4 clear, the channel's `mask_q` bit becomes 1, and the channel is no longer granted.
- R11: During a grant, `gnt_type` shows mode bits 3:2 of the granted channel and `gnt_dec` shows mode bit 5.
- R12: After reset, all `mask_q` bits are 1 and `grant`, `upd_valid` and `tc_pulse` are 0. A `mask_wr` pulse loads `mask_wdata` into `mask_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_disable | input | 1 | Controller disable from the command register |
| mask_wr | input | 1 | Strobe that loads the whole mask |
| mask_wdata | input | NUM_CH | New mask value |
| req | input | NUM_CH | Per-channel service request |
| mode_flat | input | NUM_CH*8 | Mode bytes, channel n at bits 8n+7:8n |
| base_flat | input | NUM_CH*CNT_W | Base counts, channel n at slice n |
| beat_done | input | 1 | Device strobe: one transfer beat finished |
| grant | output | NUM_CH | One-hot service grant |
| gnt_type | output | 2 | Transfer type of the granted channel |
| gnt_dec | output | 1 | Address-decrement flag of the granted channel |
| upd_valid | output | 1 | Count update present this cycle |
| upd_ch | output | $clog2(NUM_CH) | Channel being updated |
| upd_count | output | CNT_W+1 | New current count, in transfer units |
| upd_bytes | output | CNT_W+2 | New count in bytes |
| tc_pulse | output | NUM_CH | Terminal-count pulse per channel |
| mask_q | output | NUM_CH | Current mask bits |

## Verification
The bench builds the block with CNT_W=4 and WIDE=1. The narrow count puts an all-ones base count of 15 within sixteen beats, so the full run to a count of 16 (32 bytes) is reached in a short run. This exercises the base-plus-one compare at its widest value. WIDE=1 makes the byte count differ from the word count, so a missing or doubled shift shows up in every update. The four channels are programmed to cover four cases: auto-initialise rewind, self-masking in single style, cascade suppression, and block style at the top count.

// File: rtl/dma_svc_pkg.sv
package dma_svc_pkg;

    typedef enum logic [1:0] {
        XM_DEMAND  = 2'd0,
        XM_SINGLE  = 2'd1,
        XM_BLOCK   = 2'd2,
        XM_CASCADE = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        XT_VERIFY  = 2'd0,
        XT_WRITE   = 2'd1,
        XT_READ    = 2'd2,
        XT_ILLEGAL = 2'd3
    } xfer_type_e;

    typedef struct packed {
        xfer_mode_e mode;
        logic       dec;
        logic       autoinit;
        xfer_type_e kind;
    } mode_fields_t;

    typedef enum logic [1:0] {
        SV_IDLE   = 2'd0,
        SV_GRANT  = 2'd1,
        SV_UPDATE = 2'd2
    } svc_state_e;

    function automatic mode_fields_t decode_mode(input logic [7:0] mb);
        mode_fields_t f;
        f.mode     = xfer_mode_e'(mb[7:6]);
        f.dec      = mb[5];
        f.autoinit = mb[4];
        f.kind     = xfer_type_e'(mb[3:2]);
        return f;
    endfunction

endpackage

// File: rtl/dma_svc_pick.sv
module dma_svc_pick #(
    parameter int NUM_CH = 4,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] elig,
    output logic              found,
    output logic [CH_W-1:0]   idx
);

    // Fixed priority: scanning from the top down lets the lowest index win.
    always_comb begin
        found = |elig;
        idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (elig[i]) idx = CH_W'(i);
        end
    end

endmodule

// File: rtl/dma_svc_chan.sv
module dma_svc_chan
    import dma_svc_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int CW1 = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       mode_byte,
    input  logic [CNT_W-1:0] base,
    input  logic             upd_en,
    input  logic             mask_wr,
    input  logic             mask_wbit,
    output logic [CW1-1:0]   nxt_cnt,
    output logic             tc_out,
    output logic             mask_bit
);

    mode_fields_t   mf;
    logic [CW1-1:0] cur_q;
    logic [CW1-1:0] limit;
    logic           hit;

    assign mf      = decode_mode(mode_byte);
    assign nxt_cnt = cur_q + CW1'(1);
    assign limit   = {1'b0, base} + CW1'(1);
    assign hit     = (nxt_cnt == limit) && (mf.mode != XM_CASCADE);
    assign tc_out  = upd_en && hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= '0;
            mask_bit <= 1'b1;
        end else begin
            if (upd_en) begin
                cur_q <= (hit && mf.autoinit) ? '0 : nxt_cnt;
            end
            if (tc_out && !mf.autoinit) begin
                mask_bit <= 1'b1;
            end else if (mask_wr) begin
                mask_bit <= mask_wbit;
            end
        end
    end

    // R5: a beat without terminal count advances the count by one
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !tc_out) |=> cur_q == $past(cur_q) + CW1'(1));

    // R9: auto-initialise rewinds the count after terminal count
    a_r9_autoinit_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_out && mode_byte[4]) |=> cur_q == '0);

    // R10: without auto-initialise, terminal count masks the channel
    a_r10_self_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_out && !mode_byte[4]) |=> mask_bit);

    // R8: a cascade beat leaves the mask bit alone unless software writes it
    a_r8_cascade_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && mode_byte[7:6] == 2'b11 && !mask_wr) |=> $stable(mask_bit));

endmodule

// File: rtl/dma_svc_engine.sv
module dma_svc_engine
    import dma_svc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16,
    parameter bit WIDE   = 1'b0,
    localparam int CH_W = $clog2(NUM_CH),
    localparam int CW1  = CNT_W + 1,
    localparam int BW   = CNT_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctl_disable,
    input  logic                    mask_wr,
    input  logic [NUM_CH-1:0]       mask_wdata,
    input  logic [NUM_CH-1:0]       req,
    input  logic [NUM_CH*8-1:0]     mode_flat,
    input  logic [NUM_CH*CNT_W-1:0] base_flat,
    input  logic                    beat_done,
    output logic [NUM_CH-1:0]       grant,
    output logic [1:0]              gnt_type,
    output logic                    gnt_dec,
    output logic                    upd_valid,
    output logic [CH_W-1:0]         upd_ch,
    output logic [CW1-1:0]          upd_count,
    output logic [BW-1:0]           upd_bytes,
    output logic [NUM_CH-1:0]       tc_pulse,
    output logic [NUM_CH-1:0]       mask_q
);

    svc_state_e          st_q, st_d;
    logic [CH_W-1:0]     sel_q;
    logic [CH_W-1:0]     pick_idx;
    logic                pick_ok;
    logic [NUM_CH-1:0]   elig;
    logic [NUM_CH-1:0]   upd_en_v;
    logic [CW1-1:0]      nxt_v [NUM_CH];
    logic [7:0]          mode_v [NUM_CH];
    mode_fields_t        sel_mf;

    assign elig = req & ~mask_q & {NUM_CH{~ctl_disable}};

    dma_svc_pick #(.NUM_CH(NUM_CH)) u_pick (
        .elig  (elig),
        .found (pick_ok),
        .idx   (pick_idx)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign mode_v[g] = mode_flat[g*8 +: 8];
        dma_svc_chan #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode_byte (mode_flat[g*8 +: 8]),
            .base      (base_flat[g*CNT_W +: CNT_W]),
            .upd_en    (upd_en_v[g]),
            .mask_wr   (mask_wr),
            .mask_wbit (mask_wdata[g]),
            .nxt_cnt   (nxt_v[g]),
            .tc_out    (tc_pulse[g]),
            .mask_bit  (mask_q[g])
        );
    end

    // State register and selected channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SV_IDLE;
            sel_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == SV_IDLE && pick_ok) sel_q <= pick_idx;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SV_IDLE:   if (pick_ok) st_d = SV_GRANT;
            SV_GRANT: begin
                if (ctl_disable)    st_d = SV_IDLE;
                else if (beat_done) st_d = SV_UPDATE;
            end
            SV_UPDATE: st_d = SV_IDLE;
            default:   st_d = SV_IDLE;
        endcase
    end

    // Outputs per state
    always_comb begin
        grant     = '0;
        upd_valid = 1'b0;
        upd_en_v  = '0;
        unique case (st_q)
            SV_GRANT:  grant[sel_q] = 1'b1;
            SV_UPDATE: begin
                upd_valid       = 1'b1;
                upd_en_v[sel_q] = 1'b1;
            end
            default: ;
        endcase
    end

    assign sel_mf    = decode_mode(mode_v[sel_q]);
    assign gnt_type  = sel_mf.kind;
    assign gnt_dec   = sel_mf.dec;
    assign upd_ch    = sel_q;
    assign upd_count = nxt_v[sel_q];

    if (WIDE) begin : g_wide
        assign upd_bytes = {upd_count, 1'b0};
    end else begin : g_narrow
        assign upd_bytes = {1'b0, upd_count};
    end

    // R1: a disabled controller shows no grant on the following cycle
    a_r1_disable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_disable |=> grant == '0);

    // R4: grant never names more than one channel
    a_r4_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R4: grant is held until the beat ends or the controller is disabled
    a_r4_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !beat_done && !ctl_disable) |=> grant == $past(grant));

    // R2: a new grant goes only to a channel that was requesting and unmasked
    a_r2_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && $past(grant) == '0) |->
            ((($past(req) & ~$past(mask_q)) & grant) != '0));

    // R5: an update follows a beat-done seen during a grant
    a_r5_update_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && beat_done && !ctl_disable) |=> upd_valid);

endmodule

// File: tb/dma_svc_engine_tb.sv
module dma_svc_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 4;
    localparam int CW   = 4;

    typedef struct packed {
        logic [1:0] ch;
        logic [4:0] cnt;
        logic [5:0] bytes;
        logic [3:0] tc;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n;
    logic ctl_disable, mask_wr, beat_done;
    logic [NCH-1:0] mask_wdata, req;
    logic [NCH*8-1:0] mode_flat;
    logic [NCH*CW-1:0] base_flat;
    logic [NCH-1:0] grant, tc_pulse, mask_q;
    logic [1:0] gnt_type, upd_ch;
    logic gnt_dec, upd_valid;
    logic [4:0] upd_count;
    logic [5:0] upd_bytes;

    int tests = 0;
    int fails = 0;
    exp_t sb[$];
    int m_cnt [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_svc_engine #(.NUM_CH(NCH), .CNT_W(CW), .WIDE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_disable(ctl_disable), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .req(req), .mode_flat(mode_flat),
        .base_flat(base_flat), .beat_done(beat_done), .grant(grant),
        .gnt_type(gnt_type), .gnt_dec(gnt_dec), .upd_valid(upd_valid),
        .upd_ch(upd_ch), .upd_count(upd_count), .upd_bytes(upd_bytes),
        .tc_pulse(tc_pulse), .mask_q(mask_q)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_grant(input int ch, input string tag);
        for (int k = 0; k < 8; k++) begin
            if (grant != '0) break;
            @(negedge clk);
        end
        check(grant == NCH'(1 << ch), tag, int'(grant), 1 << ch);
    endtask

    // Driver: predicts the update from the requirements and pulses beat_done
    task automatic beat(input int ch);
        exp_t e;
        int nxt, base, ms;
        bit tc;
        nxt  = m_cnt[ch] + 1;
        base = int'(base_flat[ch*CW +: CW]);
        ms   = int'(mode_flat[ch*8+6 +: 2]);
        tc   = (nxt == base + 1) && (ms != 3);
        e.ch = 2'(ch);
        e.cnt = 5'(nxt);
        e.bytes = 6'(nxt * 2);
        e.tc = tc ? 4'(1 << ch) : 4'b0;
        sb.push_back(e);
        if (tc && mode_flat[ch*8+4]) m_cnt[ch] = 0;
        else m_cnt[ch] = nxt;
        beat_done = 1'b1;
        @(negedge clk);
        beat_done = 1'b0;
        check(grant == '0, "R4 grant released in update cycle", int'(grant), 0);
    endtask

    // Monitor: pops and compares every published update
    always @(negedge clk) begin
        if (rst_n && upd_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1/R5 unexpected update", int'(upd_ch), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(upd_ch == e.ch, "R5 update channel", int'(upd_ch), int'(e.ch));
                check(upd_count == e.cnt, "R5 update count", int'(upd_count), int'(e.cnt));
                check(upd_bytes == e.bytes, "R6 byte count", int'(upd_bytes), int'(e.bytes));
                check(tc_pulse == e.tc, "R7/R8 terminal count pulse", int'(tc_pulse), int'(e.tc));
            end
        end else if (rst_n && tc_pulse != '0) begin
            check(1'b0, "R7 pulse outside update", int'(tc_pulse), 0);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
        rst_n = 1'b0; ctl_disable = 1'b0; mask_wr = 1'b0; mask_wdata = '0;
        req = '0; beat_done = 1'b0;
        // ch0 single+AI+dec+write, ch1 single read, ch2 cascade, ch3 block
        mode_flat = {8'h80, 8'hC0, 8'h48, 8'h74};
        base_flat = {4'd15, 4'd0, 4'd0, 4'd1};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check(grant == '0, "R12 reset grant", int'(grant), 0);
        check(mask_q == 4'hF, "R12 reset mask", int'(mask_q), 15);
        check(upd_valid == 1'b0, "R12 reset update", int'(upd_valid), 0);
        check(tc_pulse == '0, "R12 reset tc", int'(tc_pulse), 0);

        req = 4'hF;
        repeat (3) @(negedge clk);
        check(grant == '0, "R2 masked requests not granted", int'(grant), 0);

        mask_wr = 1'b1; mask_wdata = 4'h0;
        @(negedge clk);
        mask_wr = 1'b0;
        check(mask_q == 4'h0, "R12 mask load", int'(mask_q), 0);

        wait_grant(0, "R3 lowest index wins");
        check(gnt_type == 2'd1, "R11 transfer type", int'(gnt_type), 1);
        check(gnt_dec == 1'b1, "R11 decrement flag", int'(gnt_dec), 1);
        beat(0);
        wait_grant(0, "R3 channel 0 again");
        beat(0);                       // count 2 = base+1: tc, rewind (R9)
        req = 4'b1110;

        wait_grant(1, "R3 channel 1 next");
        check(gnt_type == 2'd2, "R11 read type", int'(gnt_type), 2);
        check(gnt_dec == 1'b0, "R11 increment flag", int'(gnt_dec), 0);
        beat(1);                       // tc without AI masks ch1 (R10)
        @(negedge clk);
        check(mask_q == 4'b0010, "R10 self mask", int'(mask_q), 2);
        wait_grant(2, "R10 masked channel skipped");
        beat(2);                       // cascade: hit suppressed (R8)
        wait_grant(2, "R8 cascade regrant");
        beat(2);
        req = 4'b1000;
        @(negedge clk);
        check(mask_q == 4'b0010, "R8 cascade keeps mask", int'(mask_q), 2);

        for (int b = 0; b < 16; b++) begin
            wait_grant(3, "R3 channel 3 block");
            beat(3);
        end
        req = 4'b0000;
        @(negedge clk);
        check(mask_q == 4'b1010, "R10 block style self mask", int'(mask_q), 10);

        mask_wr = 1'b1; mask_wdata = 4'h0; req = 4'b0001; ctl_disable = 1'b1;
        @(negedge clk);
        mask_wr = 1'b0;
        repeat (3) @(negedge clk);
        check(grant == '0, "R1 disabled no grant", int'(grant), 0);
        ctl_disable = 1'b0;
        wait_grant(0, "R1 grant after enable");
        for (int h = 0; h < 3; h++) begin
            @(negedge clk);
            check(grant == 4'b0001, "R4 grant held", int'(grant), 1);
        end
        ctl_disable = 1'b1;
        @(negedge clk);
        check(grant == '0, "R1 grant withdrawn", int'(grant), 0);
        ctl_disable = 1'b0;
        wait_grant(0, "R1 regrant after abort");
        beat(0);                       // aborted grant must not have counted
        req = '0;
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R5 all updates seen", sb.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule